// File: doc/BRIEF.md
# Power-Fail Access Guard

This block sits between a bytewide clock/memory core and the outside world and decides, cycle by cycle, whether that core may be touched at all. It watches two comparator flags from the analog front end: one says the main supply is above the write-protect threshold, the other says the main supply is above the backup battery's terminal voltage. Both flags are brought into the clock domain through two-flop synchronizers before any logic looks at them.

While the supply is out of tolerance, the guard blocks every chip-enable and write strobe, holds an active-low reset output low, and steers the core onto the battery once the supply is below both thresholds. When the supply comes back, access and reset stay held for a recovery interval, counted in clock cycles, so the system can settle. If the supply dips during that interval, the interval starts again from zero. The battery path starts sealed off and is armed the first time the supply reaches a valid level. It then stays armed until the block is reset.

Top module: `pfail_guard`

## Requirements
- R1: After `rstN` is released with both flags low, `accessInhibit` is 1, `resetOutN` is 0, `batteryArmed` is 0 and `selBattery` is 0.
- R2: When `supplyAboveWpRaw` falls and stays low, `accessInhibit` is 1 at the third rising clock edge after the fall and stays 1 while the flag remains low.
- R3: When `supplyAboveWpRaw` rises and stays high, `accessInhibit` stays 1 for exactly `RECOVERY_CYCLES + 2` rising edges. It reads 0 after edge `RECOVERY_CYCLES + 3`, counting the first edge that samples the high flag as edge 1.
- R4: `resetOutN` is 0 in exactly the cycles where `accessInhibit` is 1.
- R5: If `supplyAboveWpRaw` drops while the recovery interval is still running, the interval is abandoned. When the flag returns, a full interval as in R3 is counted again from the return.
- R6: `batteryArmed` is 0 until the synchronized write-protect flag is first seen high. It becomes 1 at the third edge after the raw rise and then holds 1, whatever the flags do, until `rstN` is asserted.
- R7: `selBattery` is 1 exactly when `batteryArmed` was 1 and both synchronized flags were 0 at the previous edge. The raw-to-output latency is 3 edges.
- R8: While the supply is below the write-protect threshold but still above the battery voltage (`supplyAboveBatRaw` = 1), `selBattery` stays 0. The switchover follows the lower of the two thresholds.
- R9: `accessCe` = `reqCe` and not `accessInhibit`; `accessWe` = `reqCe` and `reqWe` and not `accessInhibit`. Both are combinational, so a write strobe in progress drops in the same cycle the inhibit rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| supplyAboveWpRaw | input | 1 | Unsynchronized flag: supply above write-protect threshold |
| supplyAboveBatRaw | input | 1 | Unsynchronized flag: supply above battery terminal voltage |
| reqCe | input | 1 | Chip-enable request from the bus side (active high) |
| reqWe | input | 1 | Write strobe request from the bus side (active high) |
| accessCe | output | 1 | Gated chip enable towards the core |
| accessWe | output | 1 | Gated write strobe towards the core |
| accessInhibit | output | 1 | 1 while all access is blocked |
| resetOutN | output | 1 | Active-low power-fail reset |
| selBattery | output | 1 | 1 selects the battery as core supply |
| batteryArmed | output | 1 | One-time battery enable, sticky until reset |

## Verification
The bench measures the release of the inhibit edge by edge after a supply return. A counter that is off by one, or that skips the synchronizer delay, moves that release a cycle early or late. It cuts the supply halfway through a recovery interval and checks that the next release comes a full interval after the return; a counter that is paused rather than cleared would release early. It drops the supply while still above the battery voltage and expects no switchover, which a design that keyed the switch on the write-protect flag alone would get wrong. It also holds the supply low before the first power-up and expects no battery selection, which catches a seal that arms from reset. Random flag and strobe traffic is compared every cycle against a bench model of the requirements.

// File: rtl/pfail_pkg.sv
package pfail_pkg;

  typedef enum logic [1:0] {
    ST_OFF     = 2'd0,
    ST_RECOVER = 2'd1,
    ST_RUN     = 2'd2
  } guardState_t;

  typedef struct packed {
    logic cntClear;     // hold the recovery counter at zero
    logic cntRun;       // advance the recovery counter
    logic accessBlock;  // block all core access, hold reset
  } ctrlStrobes_t;

endpackage

// File: rtl/pfail_sync.sv
module pfail_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] qOut
);

  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[s] <= '0;
          else       chain[s] <= dIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[s] <= '0;
          else       chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign qOut = chain[STAGES-1];

endmodule

// File: rtl/pfail_ctrl.sv
module pfail_ctrl
  import pfail_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         wpOkSync,
  input  logic         cntDone,
  output ctrlStrobes_t strobes
);

  guardState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OFF;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_OFF:     if (wpOkSync) stateNext = ST_RECOVER;
      ST_RECOVER: begin
        if (!wpOkSync)    stateNext = ST_OFF;
        else if (cntDone) stateNext = ST_RUN;
      end
      ST_RUN:     if (!wpOkSync) stateNext = ST_OFF;
      default:    stateNext = ST_OFF;
    endcase
  end

  always_comb begin
    strobes.cntClear    = (state != ST_RECOVER);
    strobes.cntRun      = (state == ST_RECOVER);
    strobes.accessBlock = (state != ST_RUN);
  end

endmodule

// File: rtl/pfail_datapath.sv
module pfail_datapath
  import pfail_pkg::*;
#(
  parameter int RECOVERY_CYCLES = 35000
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wpOkSync,
  input  logic         batOkSync,
  input  ctrlStrobes_t strobes,
  input  logic         reqCe,
  input  logic         reqWe,
  output logic         cntDone,
  output logic         accessCe,
  output logic         accessWe,
  output logic         accessInhibit,
  output logic         resetOutN,
  output logic         selBattery,
  output logic         batteryArmed
);

  localparam int CNT_W = $clog2(RECOVERY_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RECOVERY_CYCLES - 1);

  logic [CNT_W-1:0] recCnt;

  // recovery interval counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          recCnt <= '0;
    else if (strobes.cntClear)          recCnt <= '0;
    else if (strobes.cntRun && !cntDone) recCnt <= recCnt + 1'b1;
  end

  assign cntDone = (recCnt == CNT_LAST);

  // one-time battery seal: arms on the first valid supply, never disarms
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         batteryArmed <= 1'b0;
    else if (wpOkSync) batteryArmed <= 1'b1;
  end

  // switchover at the lower of the two thresholds: supply below both
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) selBattery <= 1'b0;
    else       selBattery <= batteryArmed && !wpOkSync && !batOkSync;
  end

  // access gating, combinational so a strobe dies with the inhibit
  assign accessInhibit = strobes.accessBlock;
  assign resetOutN     = !strobes.accessBlock;
  assign accessCe      = reqCe && !strobes.accessBlock;
  assign accessWe      = reqCe && reqWe && !strobes.accessBlock;

endmodule

// File: rtl/pfail_guard.sv
module pfail_guard
  import pfail_pkg::*;
#(
  parameter int RECOVERY_CYCLES = 35000,
  parameter int SYNC_STAGES     = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic supplyAboveWpRaw,
  input  logic supplyAboveBatRaw,
  input  logic reqCe,
  input  logic reqWe,
  output logic accessCe,
  output logic accessWe,
  output logic accessInhibit,
  output logic resetOutN,
  output logic selBattery,
  output logic batteryArmed
);

  logic [1:0]   flagSync;
  logic         cntDone;
  ctrlStrobes_t strobes;

  pfail_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) i_sync (
    .clk  (clk),
    .rstN (rstN),
    .dIn  ({supplyAboveBatRaw, supplyAboveWpRaw}),
    .qOut (flagSync)
  );

  pfail_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wpOkSync (flagSync[0]),
    .cntDone  (cntDone),
    .strobes  (strobes)
  );

  pfail_datapath #(.RECOVERY_CYCLES(RECOVERY_CYCLES)) i_dp (
    .clk           (clk),
    .rstN          (rstN),
    .wpOkSync      (flagSync[0]),
    .batOkSync     (flagSync[1]),
    .strobes       (strobes),
    .reqCe         (reqCe),
    .reqWe         (reqWe),
    .cntDone       (cntDone),
    .accessCe      (accessCe),
    .accessWe      (accessWe),
    .accessInhibit (accessInhibit),
    .resetOutN     (resetOutN),
    .selBattery    (selBattery),
    .batteryArmed  (batteryArmed)
  );

endmodule

// File: rtl/pfail_guard_chk.sv
module pfail_guard_chk #(
  parameter int RECOVERY_CYCLES = 35000
) (
  input logic clk,
  input logic rstN,
  input logic supplyAboveWpRaw,
  input logic accessCe,
  input logic accessWe,
  input logic accessInhibit,
  input logic selBattery,
  input logic batteryArmed
);

  localparam int RUN_W = $clog2(RECOVERY_CYCLES + 8);
  localparam logic [RUN_W-1:0] OK_NEED  = RUN_W'(RECOVERY_CYCLES + 2);
  localparam logic [RUN_W-1:0] RUN_MAX  = RUN_W'(RECOVERY_CYCLES + 4);
  localparam logic [RUN_W-1:0] LOW_NEED = RUN_W'(3);

  logic [RUN_W-1:0] okRun, lowRun;

  // consecutive-edge runs of the raw write-protect flag, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      okRun  <= '0;
      lowRun <= '0;
    end else if (supplyAboveWpRaw) begin
      lowRun <= '0;
      if (okRun != RUN_MAX) okRun <= okRun + 1'b1;
    end else begin
      okRun <= '0;
      if (lowRun != RUN_MAX) lowRun <= lowRun + 1'b1;
    end
  end

  // R2: a supply low for three edges has blocked access
  a_r2_drop_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (lowRun >= LOW_NEED) |-> accessInhibit);

  // R3 and R5: release only after an unbroken full recovery run
  a_r3_full_recovery: assert property (@(posedge clk) disable iff (!rstN)
    $fell(accessInhibit) |-> (okRun >= OK_NEED));

  // R6: the battery seal never re-closes
  a_r6_seal_sticky: assert property (@(posedge clk) disable iff (!rstN)
    batteryArmed |=> batteryArmed);

  // R7: no switchover on an unarmed battery
  a_r7_sel_needs_arm: assert property (@(posedge clk) disable iff (!rstN)
    selBattery |-> batteryArmed);

  // R9: no strobe reaches the core while blocked
  a_r9_strobes_gated: assert property (@(posedge clk) disable iff (!rstN)
    accessInhibit |-> (!accessCe && !accessWe));

endmodule

bind pfail_guard pfail_guard_chk #(.RECOVERY_CYCLES(RECOVERY_CYCLES)) i_chk (
  .clk              (clk),
  .rstN             (rstN),
  .supplyAboveWpRaw (supplyAboveWpRaw),
  .accessCe         (accessCe),
  .accessWe         (accessWe),
  .accessInhibit    (accessInhibit),
  .selBattery       (selBattery),
  .batteryArmed     (batteryArmed)
);

// File: tb/test_pfail_guard.sv
`timescale 1ns/1ps
module test_pfail_guard;

  localparam int N = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wpRaw = 1'b0, batRaw = 1'b0, reqCe = 1'b0, reqWe = 1'b0;
  logic accessCe, accessWe, accessInhibit, resetOutN, selBattery, batteryArmed;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pfail_guard #(.RECOVERY_CYCLES(N)) i_pfail_guard (
    .clk (clk), .rstN (rstN),
    .supplyAboveWpRaw (wpRaw), .supplyAboveBatRaw (batRaw),
    .reqCe (reqCe), .reqWe (reqWe),
    .accessCe (accessCe), .accessWe (accessWe),
    .accessInhibit (accessInhibit), .resetOutN (resetOutN),
    .selBattery (selBattery), .batteryArmed (batteryArmed)
  );

  // bench model of the requirements: 2-edge sync, then state/counter
  logic mS1Wp, mS2Wp, mS1Bat, mS2Bat, mArmed, mSel;
  int   mState, mCnt;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mS1Wp = 0; mS2Wp = 0; mS1Bat = 0; mS2Bat = 0;
      mArmed = 0; mSel = 0; mState = 0; mCnt = 0;
    end else begin
      mSel = mArmed && !mS2Wp && !mS2Bat;
      case (mState)
        0: if (mS2Wp) begin mState = 1; mCnt = 0; end
        1: if (!mS2Wp) mState = 0;
           else if (mCnt == N - 1) mState = 2;
           else mCnt = mCnt + 1;
        default: if (!mS2Wp) mState = 0;
      endcase
      if (mS2Wp) mArmed = 1;
      mS2Wp = mS1Wp; mS1Wp = wpRaw;
      mS2Bat = mS1Bat; mS1Bat = batRaw;
    end
  end

  function automatic logic expInhibit();
    return mState != 2;
  endfunction

  function automatic logic expWe(logic ce, logic we, logic inh);
    return ce && we && !inh;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    chk("R3", accessInhibit, expInhibit());
    chk("R4", resetOutN, !expInhibit());
    chk("R6", batteryArmed, mArmed);
    chk("R7", selBattery, mSel);
    chk("R9", accessCe, reqCe && !expInhibit());
    chk("R9", accessWe, expWe(reqCe, reqWe, expInhibit()));
  endtask

  task automatic step();
    @(negedge clk);
    compareAll();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int cyc;
    void'($urandom(32'h5eed_1743));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    step();
    // R1 reset state
    chk("R1", accessInhibit, 1'b1);
    chk("R1", resetOutN, 1'b0);
    chk("R1", batteryArmed, 1'b0);
    chk("R1", selBattery, 1'b0);

    // R6: supply low before first power-up, battery must stay unused
    repeat (10) step();
    chk("R6", selBattery, 1'b0);

    // R3: exact recovery length; R6 arming latency
    reqCe = 1; reqWe = 1;
    wpRaw = 1; batRaw = 1;
    cyc = 0;
    for (int i = 0; i < N + 10; i++) begin
      step(); cyc++;
      if (cyc == 3) chk("R6", batteryArmed, 1'b1);
      if (!accessInhibit) break;
    end
    chk("R3", 1'(cyc == N + 3), 1'b1);
    chk("R9", accessWe, 1'b1);

    // R2 and R9: drop supply, inhibit at edge 3, write strobe cut
    wpRaw = 0;
    cyc = 0;
    for (int i = 0; i < 10; i++) begin
      step(); cyc++;
      if (accessInhibit) break;
    end
    chk("R2", 1'(cyc == 3), 1'b1);
    chk("R9", accessWe, 1'b0);

    // R8: below write-protect but above battery: no switchover
    repeat (6) step();
    chk("R8", selBattery, 1'b0);
    batRaw = 0;
    repeat (3) step();
    chk("R7", selBattery, 1'b1);
    chk("R6", batteryArmed, 1'b1);

    // R5: dip halfway through recovery restarts the interval
    wpRaw = 1; batRaw = 1;
    repeat (N / 2) step();
    wpRaw = 0;
    repeat (4) step();
    chk("R5", accessInhibit, 1'b1);
    wpRaw = 1;
    cyc = 0;
    for (int i = 0; i < N + 10; i++) begin
      step(); cyc++;
      if (!accessInhibit) break;
    end
    chk("R5", 1'(cyc == N + 3), 1'b1);

    // random traffic compared against the model each cycle
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(99) == 0) wpRaw = !wpRaw;
      if ($urandom_range(15) == 0) batRaw = !batRaw;
      reqCe = 1'($urandom_range(1));
      reqWe = 1'($urandom_range(1));
      step();
    end

    // R6: reset clears the seal again
    rstN = 0;
    @(negedge clk);
    rstN = 1;
    wpRaw = 0;
    step();
    chk("R6", batteryArmed, 1'b0);
    chk("R1", accessInhibit, 1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule